// File: doc/BRIEF.md
# Receive Descriptor Closer with Frame Length Accounting

This block sits between a receive byte stream and a ring of receive descriptors held in memory. Each descriptor offers the block an empty flag, a wrap flag and a buffer pointer, which the surrounding memory presents for the index the block currently points at. Incoming frame bytes, trailing CRC bytes included, arrive with a start mark on the first byte and an end mark on the last. They are stored one by one at the buffer pointer plus a running offset.

A buffer is closed once it holds the configured maximum number of bytes, or when its frame ends. On close the block issues a descriptor update carrying the descriptor index, a length and a status word, and then steps to the next descriptor. A buffer in the middle of a frame reports the full buffer size. The closing buffer of a frame reports the total number of frame bytes stored. When a frame fills its last buffer exactly, one more descriptor is closed in the following cycle. That descriptor holds no data but carries the total length and the last mark.

Descriptors still held by software, and descriptors with an odd buffer pointer, cannot take data. The byte is then dropped and the drop is signalled. Every output is registered and appears one cycle after the input that causes it.

Top module: `rx_desc_closer`

## Requirements
- R1: Each accepted byte appears on the memory write port one cycle later. Its address is the descriptor's buffer pointer plus its offset in that buffer, counting from 0.
- R2: A buffer that reaches `cfg_max_len` bytes (must be at least 1) before its frame ends is closed in the next cycle. The update carries length `cfg_max_len` and `cls_stat` bit 1 (last) clear.
- R3: The end-of-frame byte closes its buffer in the next cycle when that buffer is not full. The length is the total number of stored bytes of the frame, with `cls_stat` bit 1 set.
- R4: An end-of-frame byte that makes its buffer exactly full closes that buffer as in R2. In the cycle after that close, one more descriptor is closed with the total frame length, bit 1 set, and no data written.
- R5: `cls_stat` bit 0 (first) is set only on the close of the first data buffer of a frame.
- R6: An empty descriptor with an odd pointer is closed as soon as a byte needs it. The update has length 0 and `cls_stat` bit 3 set. The byte is dropped and `rx_busy` pulses.
- R7: A byte that needs a new buffer while `desc_empty` is 0 is dropped. In that case nothing is written or closed, the index is kept and `rx_busy` pulses. The final close of that frame then has `cls_stat` bit 2 (overrun) set.
- R8: After each close the index moves to 0 if the closed descriptor had its wrap flag set. Otherwise it moves to the next index, modulo the table size. `cls_idx` names the descriptor that was closed.
- R9: A byte that arrives in the cycle of an extra close (R4) is dropped with an `rx_busy` pulse. Its frame's final close carries the overrun bit.
- R10: After reset no write or close is issued, `rx_busy` is 0 and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_max_len | input | LEN_W | Maximum bytes per buffer, at least 1 |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | DATA_W | Frame byte |
| desc_idx | output | IDX_W | Descriptor the block is looking at |
| desc_empty | input | 1 | Descriptor at `desc_idx` is available to the block |
| desc_wrap | input | 1 | Descriptor at `desc_idx` is the last in the ring |
| desc_ptr | input | ADDR_W | Buffer pointer of the descriptor at `desc_idx` |
| mem_we | output | 1 | Data byte write strobe |
| mem_addr | output | ADDR_W | Data byte address |
| mem_wdata | output | DATA_W | Data byte |
| cls_we | output | 1 | Descriptor close strobe |
| cls_idx | output | IDX_W | Index of the descriptor being closed |
| cls_len | output | LEN_W | Length written into the descriptor |
| cls_stat | output | 4 | Status: bit0 first, bit1 last, bit2 overrun, bit3 bad pointer |
| rx_busy | output | 1 | A byte was dropped |

## Verification
The extra empty-descriptor close that follows an exactly filled frame can land in the same cycle as the first byte of the next frame. The bench provokes this by sending a frame of exactly one buffer size with the next start-of-frame byte directly behind it. The bench's reference model requires three things from that collision. The extra close names the right descriptor with the old frame's total. The new byte is dropped with a busy pulse. The new frame's later bytes go to the descriptor after the extra one, and its final close carries the overrun bit. A second collision is also covered: a buffer-full close on the same end-of-frame byte that starts the extra close.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  // Descriptor status word as driven on cls_stat, first-in-frame in bit 0
  typedef struct packed {
    logic bad_ptr;
    logic overrun;
    logic last;
    logic first;
  } rdc_stat_t;

  localparam int STAT_W = $bits(rdc_stat_t);
endpackage

// File: rtl/rdc_ring.sv
module rdc_ring #(
  parameter int NDESC = 8,
  parameter int IDX_W = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wrap,
  output logic [IDX_W-1:0] idx
);
  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] cur, input logic wr);
    if (wr || cur == IDX_W'(NDESC - 1)) return '0;
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= step_idx(idx, wrap);
  end
endmodule

// File: rtl/rdc_oreg.sv
module rdc_oreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/rx_desc_closer.sv
module rx_desc_closer
  import rdc_pkg::*;
#(
  parameter int NDESC  = 8,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic              desc_empty,
  input  logic              desc_wrap,
  input  logic [ADDR_W-1:0] desc_ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cls_we,
  output logic [IDX_W-1:0]  cls_idx,
  output logic [LEN_W-1:0]  cls_len,
  output logic [3:0]        cls_stat,
  output logic              rx_busy
);
  localparam int WP_W = 1 + ADDR_W + DATA_W;
  localparam int CP_W = 1 + IDX_W + LEN_W + STAT_W + 1;

  function automatic logic [ADDR_W-1:0] buf_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [LEN_W-1:0]  offs);
    return base + ADDR_W'(offs);
  endfunction

  // buffer and frame state
  logic              open_q, first_q, ovr_q, xpend_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  cnt_q, flen_q;
  logic              open_n, first_n, ovr_n, xpend_n;
  logic [ADDR_W-1:0] base_n;
  logic [LEN_W-1:0]  cnt_n, flen_n;

  // named internal events
  logic ev_claim, ev_store, ev_drop, ev_full, ev_end, ev_xtra, ev_bad, ev_adv;

  logic [LEN_W-1:0]  offs, flen_e, cl_len;
  logic [ADDR_W-1:0] base_e, w_addr;
  logic              first_e, ovr_e, full;
  rdc_stat_t         cl_st;

  always_comb begin
    ev_claim = 1'b0; ev_store = 1'b0; ev_drop = 1'b0;
    ev_full  = 1'b0; ev_end   = 1'b0; ev_xtra = 1'b0; ev_bad = 1'b0;
    open_n = open_q; first_n = first_q; ovr_n = ovr_q; xpend_n = 1'b0;
    base_n = base_q; cnt_n = cnt_q; flen_n = flen_q;
    offs = '0; base_e = base_q; w_addr = '0; cl_len = '0; cl_st = '0; full = 1'b0;
    flen_e  = in_sof ? '0   : flen_q;
    first_e = in_sof ? 1'b1 : first_q;
    ovr_e   = in_sof ? 1'b0 : ovr_q;
    if (xpend_q) begin
      // empty trailing descriptor of an exactly filled frame
      ev_xtra = 1'b1;
      cl_len = flen_q; cl_st.last = 1'b1; cl_st.overrun = ovr_q;
      if (in_valid) begin
        ev_drop = 1'b1; ovr_n = 1'b1;
        flen_n = flen_e; first_n = first_e;
      end
    end else if (in_valid) begin
      flen_n = flen_e; first_n = first_e; ovr_n = ovr_e;
      if (!open_q && !desc_empty) begin
        ev_drop = 1'b1; ovr_n = 1'b1;
      end else if (!open_q && desc_ptr[0]) begin
        ev_bad = 1'b1; ev_drop = 1'b1; ovr_n = 1'b1;
        cl_st.bad_ptr = 1'b1;
      end else begin
        ev_store = 1'b1;
        ev_claim = !open_q;
        offs   = open_q ? cnt_q : '0;
        base_e = open_q ? base_q : desc_ptr;
        w_addr = buf_addr(base_e, offs);
        base_n = base_e;
        cnt_n  = offs + 1'b1;
        flen_n = flen_e + 1'b1;
        open_n = 1'b1;
        full   = (cnt_n == cfg_max_len);
        if (full || in_eof) begin
          open_n = 1'b0; first_n = 1'b0;
          cl_st.first = first_e;
          if (!full) begin
            ev_end = 1'b1;
            cl_len = flen_n; cl_st.last = 1'b1; cl_st.overrun = ovr_e;
          end else begin
            ev_full = 1'b1;
            cl_len  = cfg_max_len;
            xpend_n = in_eof;
          end
        end
      end
    end
    ev_adv = ev_xtra | ev_full | ev_end | ev_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; first_q <= 1'b0; ovr_q <= 1'b0; xpend_q <= 1'b0;
      base_q <= '0;   cnt_q   <= '0;   flen_q <= '0;
    end else begin
      open_q <= open_n; first_q <= first_n; ovr_q <= ovr_n; xpend_q <= xpend_n;
      base_q <= base_n; cnt_q   <= cnt_n;   flen_q <= flen_n;
    end
  end

  rdc_ring #(.NDESC(NDESC), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(ev_adv), .wrap(desc_wrap), .idx(desc_idx)
  );

  rdc_oreg #(.W(WP_W)) u_wport (
    .clk(clk), .rst_n(rst_n),
    .d({ev_store, w_addr, in_data}),
    .q({mem_we, mem_addr, mem_wdata})
  );

  rdc_oreg #(.W(CP_W)) u_cport (
    .clk(clk), .rst_n(rst_n),
    .d({ev_adv, desc_idx, cl_len, cl_st, ev_drop}),
    .q({cls_we, cls_idx, cls_len, cls_stat, rx_busy})
  );
endmodule

// File: rtl/rdc_props.sv
module rdc_props #(
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] cfg_max_len,
  input logic [IDX_W-1:0] desc_idx,
  input logic             mem_we,
  input logic             cls_we,
  input logic [IDX_W-1:0] cls_idx,
  input logic [LEN_W-1:0] cls_len,
  input logic [3:0]       cls_stat,
  input logic             rx_busy,
  input logic             ev_xtra
);
  // R4: the trailing empty close follows, with last set and no data
  assert_extra_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xtra |=> (cls_we && cls_stat[1] && !mem_we));

  // R7: a dropped byte is never written
  assert_drop_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !mem_we);

  // R6: odd pointer close carries no length and no data
  assert_bad_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_we && cls_stat[3]) |-> (cls_len == '0 && !mem_we && rx_busy && !cls_stat[0]));

  // R2: a non-final data close reports the full buffer size
  assert_mid_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_we && !cls_stat[1] && !cls_stat[3]) |-> (cls_len == $past(cfg_max_len)));

  // R8: index only moves with a close, and the close names the old index
  assert_idx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_we |-> (desc_idx == $past(desc_idx)));
  assert_cls_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cls_we |-> (cls_idx == $past(desc_idx)));
endmodule

bind rx_desc_closer rdc_props #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_props (
  .clk(clk), .rst_n(rst_n), .cfg_max_len(cfg_max_len), .desc_idx(desc_idx),
  .mem_we(mem_we), .cls_we(cls_we), .cls_idx(cls_idx), .cls_len(cls_len),
  .cls_stat(cls_stat), .rx_busy(rx_busy), .ev_xtra(ev_xtra)
);

// File: tb/test_rx_desc_closer.sv
`timescale 1ns/1ps
module test_rx_desc_closer;
  localparam int ND = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cfg_max_len = 16'd4;
  logic        in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0]  in_data = 0;
  logic [1:0]  desc_idx;
  logic        desc_empty, desc_wrap;
  logic [15:0] desc_ptr;
  logic        mem_we, cls_we, rx_busy;
  logic [15:0] mem_addr, cls_len;
  logic [7:0]  mem_wdata;
  logic [1:0]  cls_idx;
  logic [3:0]  cls_stat;

  // descriptor table held by the memory side
  logic        tbl_empty [ND];
  logic        tbl_wrap  [ND];
  logic [15:0] tbl_ptr   [ND];

  assign desc_empty = tbl_empty[desc_idx];
  assign desc_wrap  = tbl_wrap[desc_idx];
  assign desc_ptr   = tbl_ptr[desc_idx];

  always #4 clk = ~clk;

  rx_desc_closer #(.NDESC(ND), .ADDR_W(16), .LEN_W(16), .DATA_W(8)) i_rx_desc_closer (
    .clk(clk), .rst_n(rst_n), .cfg_max_len(cfg_max_len),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .desc_idx(desc_idx), .desc_empty(desc_empty), .desc_wrap(desc_wrap), .desc_ptr(desc_ptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cls_we(cls_we), .cls_idx(cls_idx), .cls_len(cls_len), .cls_stat(cls_stat),
    .rx_busy(rx_busy)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int m_idx = 0, m_base = 0, m_cnt = 0, m_flen = 0;
  bit m_open = 0, m_first = 0, m_ovr = 0, m_x = 0;
  int e_we, e_addr, e_data, e_cls, e_cidx, e_len, e_stat, e_busy;
  int clr_idx;
  byte dcount = 0;

  function automatic int nxt(input int i);
    return tbl_wrap[i] ? 0 : (i + 1) % ND;
  endfunction

  task automatic mclose(input int len, input int st);
    e_cls = 1; e_cidx = m_idx; e_len = len; e_stat = st;
    clr_idx = m_idx;
    m_idx = nxt(m_idx);
  endtask

  task automatic model(input bit v, input bit s, input bit e, input int d);
    int mx;
    mx = cfg_max_len;
    e_we = 0; e_addr = 0; e_data = 0; e_cls = 0; e_cidx = 0; e_len = 0; e_stat = 0; e_busy = 0;
    clr_idx = -1;
    if (m_x) begin
      mclose(m_flen, 2 + (m_ovr ? 4 : 0));
      m_x = 0;
      if (v) begin
        e_busy = 1;
        if (s) begin m_flen = 0; m_first = 1; end
        m_ovr = 1;
      end
    end else if (v) begin
      if (s) begin m_flen = 0; m_first = 1; m_ovr = 0; end
      if (!m_open && !tbl_empty[m_idx]) begin
        e_busy = 1; m_ovr = 1;
      end else if (!m_open && tbl_ptr[m_idx][0]) begin
        mclose(0, 8); e_busy = 1; m_ovr = 1;
      end else begin
        if (!m_open) begin m_base = tbl_ptr[m_idx]; m_cnt = 0; m_open = 1; end
        e_we = 1; e_addr = (m_base + m_cnt) & 16'hffff; e_data = d;
        m_cnt++; m_flen++;
        if (m_cnt == mx) begin
          mclose(mx, m_first ? 1 : 0);
          m_open = 0; m_first = 0;
          if (e) m_x = 1;
        end else if (e) begin
          mclose(m_flen, (m_first ? 1 : 0) + 2 + (m_ovr ? 4 : 0));
          m_open = 0; m_first = 0;
        end
      end
    end
  endtask

  task automatic cmp(input string req, input string what, input int act, input int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      bad = 1;
    end
  endtask

  task automatic step(input bit v, input bit s, input bit e, input string req);
    bit bad = 0;
    in_valid = v; in_sof = s; in_eof = e; in_data = dcount;
    model(v, s, e, dcount);
    if (v) dcount++;
    @(posedge clk);
    #2;
    if (clr_idx >= 0) tbl_empty[clr_idx] = 0;
    in_valid = 0; in_sof = 0; in_eof = 0;
    checks++;
    cmp(req, "mem_we", mem_we, e_we, bad);
    if (e_we) begin
      cmp(req, "mem_addr", mem_addr, e_addr, bad);
      cmp(req, "mem_wdata", mem_wdata, e_data, bad);
    end
    cmp(req, "cls_we", cls_we, e_cls, bad);
    if (e_cls) begin
      cmp(req, "cls_idx", cls_idx, e_cidx, bad);
      cmp(req, "cls_len", cls_len, e_len, bad);
      cmp(req, "cls_stat", cls_stat, e_stat, bad);
    end
    cmp(req, "rx_busy", rx_busy, e_busy, bad);
    cmp(req, "desc_idx", desc_idx, m_idx, bad);
    if (bad) failures++;
  endtask

  task automatic frame(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, i == 0, i == n - 1, req);
  endtask

  task automatic rearm();
    for (int i = 0; i < ND; i++) tbl_empty[i] = 1;
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin
      tbl_empty[i] = 1;
      tbl_wrap[i]  = (i == ND - 1);
      tbl_ptr[i]   = 16'((i + 1) * 256);
    end
    #20;
    // R10: outputs quiet during reset
    checks++;
    if (mem_we || cls_we || rx_busy || desc_idx != 0) begin
      failures++;
      $display("FAIL R10 reset outputs actual=%0b%0b%0b idx=%0d expected=000 idx=0",
               mem_we, cls_we, rx_busy, desc_idx);
    end
    @(negedge clk); rst_n = 1; #2;
    step(0, 0, 0, "R10");
    frame(3, "R3 R5 R1");
    frame(6, "R2 R5");
    step(0, 0, 0, "R2");
    rearm();
    frame(8, "R4");
    step(0, 0, 0, "R4 extra close");
    step(0, 0, 0, "R4");
    rearm();
    // R9: next start-of-frame lands on the extra close cycle
    frame(4, "R9");
    frame(3, "R9 collision");
    step(0, 0, 0, "R9");
    rearm();
    tbl_wrap[1] = 1;
    frame(5, "R8 wrap");
    step(0, 0, 0, "R8");
    tbl_wrap[1] = 0;
    rearm();
    // R7: descriptor still held by software
    tbl_empty[m_idx] = 0;
    step(1, 1, 0, "R7 busy drop");
    step(1, 0, 0, "R7 busy drop");
    rearm();
    step(1, 0, 0, "R7");
    step(1, 0, 1, "R7 overrun");
    step(0, 0, 0, "R7");
    rearm();
    // R6: odd buffer pointer
    tbl_ptr[m_idx] = tbl_ptr[m_idx] | 16'h1;
    begin
      int bi = m_idx;
      frame(2, "R6 odd pointer");
      step(0, 0, 0, "R6");
      tbl_ptr[bi] = tbl_ptr[bi] & 16'hfffe;
    end
    rearm();
    cfg_max_len = 16'd1;
    frame(2, "R4 R2 size one");
    step(0, 0, 0, "R4 size one");
    rearm();
    cfg_max_len = 16'd3;
    frame(7, "R2 R3 size three");
    step(0, 0, 0, "R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule